// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns an active-low external interrupt pin into an interrupt request for the processor core. The pin is first brought into the clock domain through a short synchronizer chain. A control register on a simple synchronous bus then picks one of two trigger modes: falling edge or low level. A qualifying trigger sets one request latch. The latch output is gated by an enable bit in the same register and by the processor's global interrupt mask.

When the core takes the interrupt, it pulses an acknowledge strobe, and that strobe clears the latch. A trigger that lands in the same cycle as the acknowledge wins over the clear. Because of this, a pulse that arrives during servicing is kept. In level mode, a line that is still low asks for service again at once, which lets several open-drain sources share the pin.

The block drives the constant address of the service vector and a raw pending flag for the core to use.

Top module: `ext_irq_ctrl`

## Requirements
- R1: In reset and right after it, the control register reads 0x10 (enabled, level mode), irqPending is 0 and irqReq is 0.
- R2: The control register is decoded at bus address 0x0C. All 8 bits can be written and read back, and bits other than 4 and 5 are plain storage. Reads at any other address return 0x00, and writes to any other address change nothing.
- R3: With bit 5 = 0 (level mode) and bit 4 = 1, a low pin sets irqPending. The pin passes through two synchronizer flops and the latch, so the flag is visible after the third rising clock edge.
- R4: With bit 5 = 1 (edge mode) and bit 4 = 1, only a falling edge of the synchronized pin sets irqPending. A line that stays low does not set the latch again after it has been cleared.
- R5: irqReq is high exactly when irqPending = 1, bit 4 = 1 and cpuMaskI = 0.
- R6: While bit 4 = 0, pin activity does not set the latch. Clearing bit 4 removes irqReq but keeps a latch that is already set, so the request comes back when bit 4 is set again.
- R7: A one-cycle irqAck clears the latch. A trigger in the same cycle has priority and leaves the latch set: a new falling edge in edge mode, or a line still low in level mode.
- R8: irqVector always carries 0x1FFA, the address of the high byte of the service address. The low byte is at 0x1FFB.
- R9: A trigger that arrives while cpuMaskI = 1 is held in the latch and raises irqReq as soon as the mask clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIrqN | input | 1 | Asynchronous active-low interrupt pin |
| busAddr | input | 8 | Bus address |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Combinational read data |
| cpuMaskI | input | 1 | Processor global interrupt mask (1 = masked) |
| irqAck | input | 1 | One-cycle strobe when the interrupt is taken |
| irqReq | output | 1 | Gated interrupt request to the core |
| irqPending | output | 1 | Raw request latch state |
| irqVector | output | 16 | Service vector address |

## Verification
The acknowledge that clears the latch can fall in the same clock cycle as a new trigger that sets it. The bench provokes this in edge mode. It drives the pin low, counts two rising edges until the synchronized falling edge is present, and asserts irqAck for exactly that cycle. It then expects irqPending to stay at 1, and expects a second acknowledge one cycle later, with no edge, to clear the flag. In level mode the same collision occurs whenever the core acknowledges while the line is still low. The bench judges this by seeing irqReq return as soon as the mask is clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned EN_BIT   = 4;
  localparam int unsigned EDGE_BIT = 5;
  localparam logic [REG_W-1:0] CTRL_RESET = 8'h10;

  // strobes from control to datapath
  typedef struct packed {
    logic ctrlWrite;
    logic latchSet;
    logic latchClr;
  } irqStrobe_t;
endpackage

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIrqN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  irqStrobe_t        strobe,
  output logic              syncLevel,
  output logic              prevLevel,
  output logic [REG_W-1:0]  ctrlQ,
  output logic              latchQ,
  output logic [REG_W-1:0]  busRdData
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  // synchronizer chain, idle level high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= pinIrqN;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[LAST];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ctrlQ <= CTRL_RESET;
    else if (strobe.ctrlWrite) ctrlQ <= busWrData;
  end

  // set dominates clear
  always_ff @(posedge clk) begin
    if (!rstN)                latchQ <= 1'b0;
    else if (strobe.latchSet) latchQ <= 1'b1;
    else if (strobe.latchClr) latchQ <= 1'b0;
  end

  assign syncLevel = syncQ[LAST];
  assign prevLevel = prevQ;

  always_comb begin
    busRdData = '0;
    if (busAddr == CTRL_ADDR) busRdData = ctrlQ;
  end
endmodule

// File: rtl/ext_irq_control.sv
module ext_irq_control
  import ext_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C
) (
  input  logic              syncLevel,
  input  logic              prevLevel,
  input  logic [REG_W-1:0]  ctrlQ,
  input  logic              latchQ,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              cpuMaskI,
  input  logic              irqAck,
  output irqStrobe_t        strobe,
  output logic              irqReq
);
  logic enable;
  logic edgeMode;
  logic fallSeen;
  logic trigger;

  assign enable   = ctrlQ[EN_BIT];
  assign edgeMode = ctrlQ[EDGE_BIT];
  assign fallSeen = prevLevel & ~syncLevel;
  assign trigger  = edgeMode ? fallSeen : ~syncLevel;

  always_comb begin
    strobe           = '0;
    strobe.ctrlWrite = busWrEn && (busAddr == CTRL_ADDR);
    strobe.latchSet  = enable & trigger;
    strobe.latchClr  = irqAck;
  end

  assign irqReq = latchQ & enable & ~cpuMaskI;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter logic [15:0] VEC_ADDR = 16'h1FFA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIrqN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic              cpuMaskI,
  input  logic              irqAck,
  output logic              irqReq,
  output logic              irqPending,
  output logic [15:0]       irqVector
);
  irqStrobe_t       strobe;
  logic             syncLevel;
  logic             prevLevel;
  logic [REG_W-1:0] ctrlQ;
  logic             latchQ;

  ext_irq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .pinIrqN(pinIrqN), .busAddr(busAddr),
    .busWrData(busWrData), .strobe(strobe), .syncLevel(syncLevel),
    .prevLevel(prevLevel), .ctrlQ(ctrlQ), .latchQ(latchQ),
    .busRdData(busRdData)
  );

  ext_irq_control #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) ctl_i (
    .syncLevel(syncLevel), .prevLevel(prevLevel), .ctrlQ(ctrlQ),
    .latchQ(latchQ), .busAddr(busAddr), .busWrEn(busWrEn),
    .cpuMaskI(cpuMaskI), .irqAck(irqAck), .strobe(strobe), .irqReq(irqReq)
  );

  assign irqPending = latchQ;
  assign irqVector  = VEC_ADDR;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [REG_W-1:0]  busWrData,
  input logic              cpuMaskI,
  input logic              irqAck,
  input logic              irqReq,
  input logic              irqPending,
  input logic [REG_W-1:0]  ctrlQ
);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CTRL_ADDR) |=> ctrlQ == $past(busWrData));

  assert_req_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqPending && !cpuMaskI));

  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(ctrlQ[EN_BIT]));

  assert_clear_needs_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPending) |-> $past(irqAck));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .cpuMaskI(cpuMaskI), .irqAck(irqAck),
  .irqReq(irqReq), .irqPending(irqPending), .ctrlQ(ctrlQ)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIrqN = 1'b1;
  logic [7:0] busAddr = 8'h0C;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       cpuMaskI = 1'b0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic       irqPending;
  logic [15:0] irqVector;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pinIrqN(pinIrqN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .cpuMaskI(cpuMaskI), .irqAck(irqAck), .irqReq(irqReq),
    .irqPending(irqPending), .irqVector(irqVector)
  );

  typedef struct packed {
    logic [7:0] ctrl;
    logic       pin;
    logic       mask;
    logic       ack;
    logic       expPend;
    logic       expReq;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 idle level
    '{8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 low line
    '{8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 masked
    '{8'h10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 ack while low
    '{8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 latched after release
    '{8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 ack clears
    '{8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 edge idle
    '{8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 falling edge
    '{8'h30, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 steady low no reset
    '{8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 rise no set
    '{8'h30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 edge while masked
    '{8'h30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 unmask serves
    '{8'h30, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 ack clears
    '{8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 disabled ignored
    '{8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 disabled idle
    '{8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 edge enabled
    '{8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 disable keeps latch
    '{8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 re-enable
    '{8'h30, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}  // R7 ack clears
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic applyVec(input vec_t v, input int idx);
    @(negedge clk);
    busAddr = 8'h0C; busWrEn = 1'b1; busWrData = v.ctrl;
    pinIrqN = v.pin; cpuMaskI = v.mask; irqAck = v.ack;
    @(negedge clk);
    busWrEn = 1'b0; irqAck = 1'b0;
    repeat (4) @(negedge clk);
    check($sformatf("vec%0d pending", idx), {15'd0, irqPending}, {15'd0, v.expPend});
    check($sformatf("vec%0d request", idx), {15'd0, irqReq}, {15'd0, v.expReq});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 16'd1, 16'd0);
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check("R1 reg in reset", {8'd0, busRdData}, 16'h0010);
    check("R1 pending in reset", {15'd0, irqPending}, 16'd0);
    check("R1 req in reset", {15'd0, irqReq}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg after reset", {8'd0, busRdData}, 16'h0010);
    check("R1 req after reset", {15'd0, irqReq}, 16'd0);
    check("R8 vector", irqVector, 16'h1FFA);

    // R3 latency: level low visible after third rising edge
    pinIrqN = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 not yet after two edges", {15'd0, irqPending}, 16'd0);
    @(negedge clk);
    check("R3 set after three edges", {15'd0, irqPending}, 16'd1);
    pinIrqN = 1'b1; irqAck = 1'b1;
    @(negedge clk);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    check("R7 cleared after release", {15'd0, irqPending}, 16'd0);

    for (int i = 0; i < NVEC; i++) applyVec(VECS[i], i);

    // R2 plain storage and decoding
    @(negedge clk);
    busAddr = 8'h0C; busWrEn = 1'b1; busWrData = 8'hCF;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R2 readback", {8'd0, busRdData}, 16'h00CF);
    busAddr = 8'h0D; busWrEn = 1'b1; busWrData = 8'h00;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R2 other address reads zero", {8'd0, busRdData}, 16'h0000);
    busAddr = 8'h0C;
    #1 check("R2 other address write ignored", {8'd0, busRdData}, 16'h00CF);

    // R7 edge coinciding with ack
    busWrEn = 1'b1; busWrData = 8'h30;
    @(negedge clk);
    busWrEn = 1'b0; pinIrqN = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 setup pending", {15'd0, irqPending}, 16'd1);
    pinIrqN = 1'b1;
    repeat (4) @(negedge clk);
    pinIrqN = 1'b0;
    repeat (2) @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    check("R7 edge beats ack", {15'd0, irqPending}, 16'd1);
    @(negedge clk);
    irqAck = 1'b0;
    check("R7 second ack clears", {15'd0, irqPending}, 16'd0);
    check("R8 vector steady", irqVector, 16'h1FFA);

    summary();
  end
endmodule